// File: doc/BRIEF.md
# Grouped GPIO Edge Interrupt Aggregator

The block watches thirteen synchronized GPIO pin levels and records edges on them in sticky status bits. Each pin has its own two-bit detect mode, supplied by the pin controller, that selects no detection, falling edges, rising edges or both. A recorded edge stays pending until the host clears it by writing a one to its status bit. A mask bit per pin decides whether the pending edge reaches the host. All thirteen pins share one registered interrupt line.

The pins are split unevenly over two register groups. The first group holds pins 0 to 6 in bits 6:0 and the second holds pins 7 to 12 in bits 5:0. The status pair sits at 0x4E0B/0x4E0C and the mask pair at 0x4E19/0x4E1A. A handler reads status, services the pending pins and writes ones to clear them. It then reads status again, because edges that arrive while it works stay pending.

Top module: `gpio_edge_irq_agg`

## Requirements
- R1: While reset is low, and in the first cycle after it, every status bit is 0, every mask bit is 1 (mask reads 0x7F and 0x3F) and the interrupt line is 0. The previous-level state takes the live pin levels during reset, so pins that sit high through reset record no edge.
- R2: Detect mode per pin, in bits [2i+1:2i] of the mode input: 0 records nothing, 1 records falling edges, 2 records rising edges, 3 records both. An edge on the pins is visible in status one clock after the level changes.
- R3: A status bit stays set after its pin returns to its old level, until the host clears it.
- R4: Writing a byte to a status register clears each bit whose written bit is 1. Bits written as 0 keep their value.
- R5: When an edge arrives in the same cycle as a clearing write to its bit, the bit stays set.
- R6: Pins 0 to 6 map to bits 6:0 at 0x4E0B and 0x4E19. Pins 7 to 12 map to bits 5:0 at 0x4E0C and 0x4E1A. Bit 7 of group 0 and bits 7:6 of group 1 read 0, and writes to them do nothing.
- R7: A mask bit of 1 keeps its pin off the interrupt line, and a mask bit of 0 lets it through. A write to a mask register loads bits for its own group only.
- R8: The interrupt line is a register holding the OR of status AND NOT mask over all pins. It rises one clock after an unmasked status bit is set and falls one clock after the last such bit is cleared or masked.
- R9: Reads of any other address return 0. Writes to any other address change no status or mask bit.
- R10: Status captures edges whether or not the pin is masked. Unmasking a pending pin raises the interrupt line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_level | input | 13 | Synchronized pin levels, bit i is pin i |
| pin_mode | input | 26 | Detect mode per pin, bits [2i+1:2i] |
| bus_addr | input | 16 | Register address for read and write |
| bus_wr_en | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| irq_out | output | 1 | Interrupt line to the host, active high |

## Verification
A status bit lost or stuck in the wrong state shows at the status read port in the cycle after the edge or clear that should have changed it. It shows on the interrupt line one cycle later. A wrong mask bit shows straight away on a mask read, and on the interrupt line within one clock of the pin going pending. A previous-level register loaded wrongly at reset shows as a pending bit on the very first status read. The tests sample in those exact cycles, so a slip of one cycle in the interrupt register is caught.

// File: rtl/gpio_irq_pkg.sv
// Shared types for the grouped GPIO edge interrupt aggregator.
// Assumes: the detect-mode codes below are fixed by the pin controller.
package gpio_irq_pkg;

    typedef enum logic [1:0] {
        DET_OFF  = 2'd0,
        DET_FALL = 2'd1,
        DET_RISE = 2'd2,
        DET_BOTH = 2'd3
    } det_mode_e;

endpackage

// File: rtl/pin_edge_detect.sv
// Per-pin edge detector. Compares each pin with its level from the
// previous cycle and flags the edges that the pin's mode asks for.
// Assumes: pin_level is already synchronized. During reset the previous
// level follows the live pin, so reset release makes no edge.
module pin_edge_detect
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PINS = 13
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_PINS-1:0]   pin_level,
    input  logic [2*NUM_PINS-1:0] pin_mode,
    output logic [NUM_PINS-1:0]   edge_hit
);

    logic [NUM_PINS-1:0] prev_level;

    // Keep the previous level; during reset load the live level.
    always_ff @(posedge clk) begin
        prev_level <= pin_level;
    end

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        det_mode_e mode;
        logic      rise;
        logic      fall;

        assign mode = det_mode_e'(pin_mode[2*p +: 2]);
        assign rise = pin_level[p] & ~prev_level[p];
        assign fall = ~pin_level[p] & prev_level[p];

        // Select the edges this pin's mode records.
        always_comb begin
            unique case (mode)
                DET_OFF:  edge_hit[p] = 1'b0;
                DET_FALL: edge_hit[p] = fall;
                DET_RISE: edge_hit[p] = rise;
                DET_BOTH: edge_hit[p] = rise | fall;
                default:  edge_hit[p] = 1'b0;
            endcase
        end
    end

    // Reset needs no branch: the previous level copies the pin every cycle.
    logic unused_rst;
    assign unused_rst = rst_n;

endmodule

// File: rtl/irq_reg_bank.sv
// Status and mask registers split over two groups, with address decode.
// Status is sticky and cleared by writing one. A new edge beats a clear.
// Assumes: group sizes fit in REG_W bits and addresses of a pair are adjacent.
module irq_reg_bank #(
    parameter int                NUM_PINS  = 13,
    parameter int                GRP0_PINS = 7,
    parameter int                REG_W     = 8,
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] STAT_BASE = 16'h4E0B,
    parameter logic [ADDR_W-1:0] MASK_BASE = 16'h4E19
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] edge_hit,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr_en,
    input  logic [REG_W-1:0]    bus_wdata,
    output logic [REG_W-1:0]    bus_rdata,
    output logic [NUM_PINS-1:0] status_vec,
    output logic [NUM_PINS-1:0] mask_vec
);

    localparam int                GRP1_PINS = NUM_PINS - GRP0_PINS;
    localparam logic [ADDR_W-1:0] STAT_G0   = STAT_BASE;
    localparam logic [ADDR_W-1:0] STAT_G1   = ADDR_W'(STAT_BASE + 1);
    localparam logic [ADDR_W-1:0] MASK_G0   = MASK_BASE;
    localparam logic [ADDR_W-1:0] MASK_G1   = ADDR_W'(MASK_BASE + 1);

    logic                sel_s0, sel_s1, sel_m0, sel_m1;
    logic [NUM_PINS-1:0] clr_vec;
    logic [NUM_PINS-1:0] mask_d;

    assign sel_s0 = (bus_addr == STAT_G0);
    assign sel_s1 = (bus_addr == STAT_G1);
    assign sel_m0 = (bus_addr == MASK_G0);
    assign sel_m1 = (bus_addr == MASK_G1);

    // Spread a write to either group onto the clear vector and the next mask.
    always_comb begin
        clr_vec = '0;
        mask_d  = mask_vec;
        for (int i = 0; i < NUM_PINS; i++) begin
            if (i < GRP0_PINS) begin
                if (bus_wr_en && sel_s0) clr_vec[i] = bus_wdata[i];
                if (bus_wr_en && sel_m0) mask_d[i]  = bus_wdata[i];
            end else begin
                if (bus_wr_en && sel_s1) clr_vec[i] = bus_wdata[i-GRP0_PINS];
                if (bus_wr_en && sel_m1) mask_d[i]  = bus_wdata[i-GRP0_PINS];
            end
        end
    end

    // Sticky status: clear on write-one, set on edge, the edge wins.
    always_ff @(posedge clk) begin
        if (!rst_n) status_vec <= '0;
        else        status_vec <= (status_vec & ~clr_vec) | edge_hit;
    end

    // Mask register: all pins blocked after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) mask_vec <= '1;
        else        mask_vec <= mask_d;
    end

    // Read mux: place the addressed group in the low bits, pad with zeros.
    always_comb begin
        bus_rdata = '0;
        for (int b = 0; b < REG_W; b++) begin
            if (b < GRP0_PINS && sel_s0) bus_rdata[b] = status_vec[b];
            if (b < GRP0_PINS && sel_m0) bus_rdata[b] = mask_vec[b];
            if (b < GRP1_PINS && sel_s1) bus_rdata[b] = status_vec[b+GRP0_PINS];
            if (b < GRP1_PINS && sel_m1) bus_rdata[b] = mask_vec[b+GRP0_PINS];
        end
    end

endmodule

// File: rtl/gpio_edge_irq_agg.sv
// Top of the grouped GPIO edge interrupt aggregator. Edge detection feeds
// the sticky status bank, and a register ORs unmasked status into one line.
// Assumes: a single host master, with reads and writes both addressed by bus_addr.
module gpio_edge_irq_agg #(
    parameter int                NUM_PINS  = 13,
    parameter int                GRP0_PINS = 7,
    parameter int                REG_W     = 8,
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] STAT_BASE = 16'h4E0B,
    parameter logic [ADDR_W-1:0] MASK_BASE = 16'h4E19
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_PINS-1:0]   pin_level,
    input  logic [2*NUM_PINS-1:0] pin_mode,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic                  bus_wr_en,
    input  logic [REG_W-1:0]      bus_wdata,
    output logic [REG_W-1:0]      bus_rdata,
    output logic                  irq_out
);

    logic [NUM_PINS-1:0] edge_hit;
    logic [NUM_PINS-1:0] status_vec;
    logic [NUM_PINS-1:0] mask_vec;

    pin_edge_detect #(.NUM_PINS(NUM_PINS)) edge_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_level (pin_level),
        .pin_mode  (pin_mode),
        .edge_hit  (edge_hit)
    );

    irq_reg_bank #(
        .NUM_PINS  (NUM_PINS),
        .GRP0_PINS (GRP0_PINS),
        .REG_W     (REG_W),
        .ADDR_W    (ADDR_W),
        .STAT_BASE (STAT_BASE),
        .MASK_BASE (MASK_BASE)
    ) bank_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .edge_hit   (edge_hit),
        .bus_addr   (bus_addr),
        .bus_wr_en  (bus_wr_en),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .status_vec (status_vec),
        .mask_vec   (mask_vec)
    );

    // Registered interrupt: any status bit whose mask is clear.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_out <= 1'b0;
        else        irq_out <= |(status_vec & ~mask_vec);
    end

endmodule

// File: rtl/gpio_edge_irq_chk.sv
// Assertion checker for gpio_edge_irq_agg, attached by bind below.
// Assumes: reset is held low for at least two clocks at start.
module gpio_edge_irq_chk #(
    parameter int                NUM_PINS  = 13,
    parameter int                GRP0_PINS = 7,
    parameter int                REG_W     = 8,
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] STAT_BASE = 16'h4E0B
) (
    input logic                clk,
    input logic                rst_n,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic                bus_wr_en,
    input logic [REG_W-1:0]    bus_rdata,
    input logic [NUM_PINS-1:0] status_vec,
    input logic [NUM_PINS-1:0] mask_vec,
    input logic                irq_out
);

    localparam logic [ADDR_W-1:0] STAT_G1   = ADDR_W'(STAT_BASE + 1);
    localparam int                GRP1_PINS = NUM_PINS - GRP0_PINS;

    logic pend_any;
    assign pend_any = |(status_vec & ~mask_vec);

    // R1: reset leaves the line low, status empty and all masks set.
    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (!irq_out && status_vec == '0 && mask_vec == '1));

    // R3: with no bus write, no status bit drops.
    assert_status_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr_en |=> ((status_vec & $past(status_vec)) == $past(status_vec)));

    // R8: the line follows unmasked pending state one clock later.
    assert_irq_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pend_any |=> irq_out);

    // R7: nothing unmasked pending means the line drops next clock.
    assert_mask_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !pend_any |=> !irq_out);

    // R6: unused upper bits of the status group registers read zero.
    assert_unused_g0_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == STAT_BASE) |-> (bus_rdata[REG_W-1:GRP0_PINS] == '0));
    assert_unused_g1_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == STAT_G1) |-> (bus_rdata[REG_W-1:GRP1_PINS] == '0));

endmodule

bind gpio_edge_irq_agg gpio_edge_irq_chk #(
    .NUM_PINS  (NUM_PINS),
    .GRP0_PINS (GRP0_PINS),
    .REG_W     (REG_W),
    .ADDR_W    (ADDR_W),
    .STAT_BASE (STAT_BASE)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_wr_en  (bus_wr_en),
    .bus_rdata  (bus_rdata),
    .status_vec (status_vec),
    .mask_vec   (mask_vec),
    .irq_out    (irq_out)
);

// File: tb/gpio_edge_irq_agg_tb_top.sv
// Directed bench: one task per scenario, each checking its own results.
module gpio_edge_irq_agg_tb_top;

    localparam logic [15:0] S0 = 16'h4E0B, S1 = 16'h4E0C;
    localparam logic [15:0] M0 = 16'h4E19, M1 = 16'h4E1A;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [12:0] pin_level = 13'h1020;
    logic [25:0] pin_mode;
    logic [15:0] bus_addr = 16'h0;
    logic        bus_wr_en = 1'b0;
    logic [7:0]  bus_wdata = 8'h0;
    logic [7:0]  bus_rdata;
    logic        irq_out;

    int n_run = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    gpio_edge_irq_agg dut_i (
        .clk(clk), .rst_n(rst_n), .pin_level(pin_level), .pin_mode(pin_mode),
        .bus_addr(bus_addr), .bus_wr_en(bus_wr_en), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_out(irq_out)
    );

    // Modes: pin0 off, pin1 fall, pin2 rise, pin3 both, pins 8 and 10 rise, others both.
    always_comb begin
        pin_mode = {13{2'd3}};
        pin_mode[1:0]   = 2'd0;
        pin_mode[3:2]   = 2'd1;
        pin_mode[5:4]   = 2'd2;
        pin_mode[7:6]   = 2'd3;
        pin_mode[17:16] = 2'd2;
        pin_mode[21:20] = 2'd2;
    end

    task automatic check(input string req, input int got, input int exp);
        n_run++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic rd(input logic [15:0] a, output logic [7:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr_en = 1'b1;
        @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    // Change levels at a negedge and wait until status shows the result.
    task automatic set_pins(input logic [12:0] lv);
        @(negedge clk);
        pin_level = lv;
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        rd(S0, d); check("R1 status0 after reset", d, 8'h00);
        rd(S1, d); check("R1 status1 after reset", d, 8'h00);
        rd(M0, d); check("R1 mask0 after reset", d, 8'h7F);
        rd(M1, d); check("R1 mask1 after reset", d, 8'h3F);
        check("R1 irq after reset", irq_out, 0);
    endtask

    task automatic t_modes();
        logic [7:0] d;
        set_pins(pin_level | 13'h000F);
        rd(S0, d); check("R2 rising on pins 0-3", d, 8'h0C);
        wr(S0, 8'h0F);
        rd(S0, d); check("R4 clear all group0", d, 8'h00);
        set_pins(pin_level & ~13'h000F);
        rd(S0, d); check("R2 falling on pins 0-3", d, 8'h0A);
        wr(S0, 8'h0F);
    endtask

    task automatic t_groups();
        logic [7:0] d;
        set_pins(pin_level | 13'h00C0);
        rd(S0, d); check("R6 pin6 in group0 bit6", d, 8'h40);
        rd(S1, d); check("R6 pin7 in group1 bit0", d, 8'h01);
        wr(S0, 8'hFF); wr(S1, 8'hFF);
        rd(S1, d); check("R6 group1 cleared", d, 8'h00);
        wr(M0, 8'hFF);
        rd(M0, d); check("R6 mask0 unused bit reads 0", d, 8'h7F);
        set_pins(pin_level & ~13'h00C0);
        wr(S0, 8'hFF); wr(S1, 8'hFF);
    endtask

    task automatic t_sticky();
        logic [7:0] d;
        set_pins(pin_level | 13'h0100);
        set_pins(pin_level & ~13'h0100);
        rd(S1, d); check("R3 pin8 stays pending", d, 8'h02);
        wr(S1, 8'h00);
        rd(S1, d); check("R4 zero write keeps bit", d, 8'h02);
        wr(S1, 8'h01);
        rd(S1, d); check("R4 other bit write keeps bit", d, 8'h02);
        wr(S1, 8'h02);
        rd(S1, d); check("R4 one write clears bit", d, 8'h00);
    endtask

    task automatic t_irq();
        logic [7:0] d;
        set_pins(pin_level | 13'h0200);
        @(negedge clk);
        rd(S1, d); check("R10 masked pin9 captured", d, 8'h04);
        check("R7 masked pin keeps irq low", irq_out, 0);
        wr(M1, 8'h3B);
        check("R8 irq not yet after unmask", irq_out, 0);
        @(negedge clk);
        check("R10 unmask raises irq", irq_out, 1);
        wr(S1, 8'h04);
        check("R8 irq held one clock after clear", irq_out, 1);
        @(negedge clk);
        check("R8 irq low after clear", irq_out, 0);
        set_pins(pin_level & ~13'h0200);
        @(negedge clk);
        check("R8 irq on unmasked falling edge", irq_out, 1);
        wr(M1, 8'h3F);
        @(negedge clk);
        check("R7 remask drops irq", irq_out, 0);
        wr(S1, 8'h04);
    endtask

    task automatic t_collision();
        logic [7:0] d;
        set_pins(pin_level | 13'h0400);
        set_pins(pin_level & ~13'h0400);
        @(negedge clk);
        bus_addr = S1; bus_wdata = 8'h08; bus_wr_en = 1'b1;
        pin_level = pin_level | 13'h0400;
        @(negedge clk);
        bus_wr_en = 1'b0;
        rd(S1, d); check("R5 edge beats clear", d, 8'h08);
        wr(S1, 8'h08);
        rd(S1, d); check("R5 later clear works", d, 8'h00);
        set_pins(pin_level & ~13'h0400);
    endtask

    task automatic t_unmapped();
        logic [7:0] d;
        set_pins(pin_level | 13'h0001);
        set_pins(pin_level | 13'h0008);
        wr(16'h4E00, 8'hFF);
        wr(16'h4E1B, 8'h00);
        wr(16'h4E0D, 8'hFF);
        rd(16'h4E00, d); check("R9 unmapped read is 0", d, 8'h00);
        rd(S0, d); check("R9 status kept, pin0 off", d, 8'h08);
        rd(M1, d); check("R9 mask1 kept", d, 8'h3F);
        wr(S0, 8'h08);
    endtask

    initial begin : watchdog
        #1000000;
        n_run++; n_fail++;
        $display("FAIL watchdog: got timeout expected finish");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_modes();
        t_groups();
        t_sticky();
        t_irq();
        t_collision();
        t_unmapped();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule